// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point numbers in the common single-precision layout. The layout is one sign bit on top, then an 8-bit exponent stored with an offset of 127, then a 23-bit fraction at the bottom. A normal operand is worth (-1)^sign x 1.fraction x 2^(exponent-127). The block splits each operand into its fields, classifies it and puts back the implicit leading one. It then forms the biased result exponent and the 48-bit significand product. Next it normalizes, rounds to nearest with ties to even from guard, round and sticky bits, and normalizes again when rounding carries. Finally it packs the result with the sign and two range flags.

Work moves through a two-stage pipeline. Stage one classifies the operands, sums the exponents and multiplies the significands. Stage two normalizes, rounds, checks the range and resolves the special values. A qualifier travels beside the operands so that the result appears two clock edges after it is accepted. A new pair may be accepted on every cycle.

Denormal operands (exponent field zero, fraction nonzero) are treated as zero. Results below the normal range flush to zero.

Top module: `fpm_mul`

## Requirements
- R1: The sign bit (bit 31) of every non-NaN result equals the XOR of the two operand sign bits.
- R2: For two normal operands whose product lies in range, the result exponent is exp_a + exp_b - 127. It is one higher when the significand product is 2.0 or more, and in that case the product is shifted right by one before rounding.
- R3: The significand is rounded to 23 fraction bits. Rounding is to nearest, and an exact halfway case goes to the value with a zero last fraction bit. A carry out of rounding renormalizes the result to 1.0 and adds one to the exponent.
- R4: A finite result whose final biased exponent is 255 or more returns infinity with the computed sign (exponent field 0xFF, fraction 0) and raises `ovf_o`. `ovf_o` and `unf_o` are never high together.
- R5: A product of nonzero finite operands whose final biased exponent is 0 or less returns zero with the computed sign and raises `unf_o`. A result with biased exponent 1 is returned unchanged with no flag.
- R6: An operand with exponent field 0xFF and a nonzero fraction (NaN), or infinity times a zero or denormal operand, gives 0x7FC00000 with both flags low.
- R7: Infinity (exponent 0xFF, fraction 0) times a normal operand or times infinity gives infinity with the computed sign, with both flags low.
- R8: An operand with exponent field 0 (zero or denormal) times a finite operand gives zero with the computed sign, with both flags low.
- R9: `out_valid_o` rises exactly two rising clock edges after `in_valid_i` is sampled high. Back-to-back inputs give back-to-back results in the same order.
- R10: While `rst_n` is low, `out_valid_o`, `result_o`, `ovf_o` and `unf_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair is presented this cycle |
| a_i | input | 32 | First operand, single-precision layout |
| b_i | input | 32 | Second operand, single-precision layout |
| out_valid_o | output | 1 | Result and flags are valid |
| result_o | output | 32 | Product, single-precision layout |
| ovf_o | output | 1 | Result exceeded the normal range and was set to infinity |
| unf_o | output | 1 | Result fell below the normal range and was flushed to zero |

## Verification
The bench aims at the rounding corners.

- An exact halfway case with an odd last bit must round up, and one with an even last bit must stay put. A design that always rounds halves up, or that ignores the sticky bits, returns a value one unit off.
- A product just below 2.0 must carry out of rounding into the next binade. If the second normalization is missing, the result comes back with a zero fraction and an exponent one too small.
- Both edges of the exponent range are probed on each side, along with both signs of overflow and underflow. A design that compares the exponent without its sign bit turns underflow into a huge number.
- The special pairs are probed: infinity times zero, NaN with a valid operand, and a signalling NaN. A design that tests only the exponent returns infinity where a NaN is due.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;

    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int SIG_W   = FRAC_W + 1;
    localparam int PROD_W  = 2 * SIG_W;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP = (1 << EXP_W) - 1;
    localparam int XW      = EXP_W + 3;

    typedef enum logic [1:0] {
        CLS_ZERO,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fpm_cls_e;

    typedef enum logic [1:0] {
        KIND_NUM,
        KIND_ZERO,
        KIND_INF,
        KIND_NAN
    } fpm_kind_e;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [SIG_W-1:0] sig;
        fpm_cls_e         cls;
    } fpm_opnd_t;

    typedef struct packed {
        logic                    vld;
        logic                    sgn;
        fpm_kind_e               kind;
        logic signed [XW-1:0]    exp;
        logic [PROD_W-1:0]       prod;
    } fpm_s1_t;

    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              ovf;
        logic              unf;
    } fpm_s2_t;

    typedef struct packed {
        fpm_s1_t s1;
        fpm_s2_t s2;
    } fpm_state_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
    import fpm_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output fpm_opnd_t         opnd_o
);
    logic [EXP_W-1:0]  exp_f;
    logic [FRAC_W-1:0] frac_f;

    always_comb begin
        exp_f         = word_i[WORD_W-2 -: EXP_W];
        frac_f        = word_i[FRAC_W-1:0];
        opnd_o.sgn    = word_i[WORD_W-1];
        opnd_o.exp    = exp_f;
        opnd_o.sig    = {1'b1, frac_f};
        if (exp_f == '0) begin
            // denormals are flushed: treated as zero
            opnd_o.cls = CLS_ZERO;
            opnd_o.sig = '0;
        end else if (exp_f == {EXP_W{1'b1}}) begin
            opnd_o.cls = (frac_f == '0) ? CLS_INF : CLS_NAN;
        end else begin
            opnd_o.cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
    import fpm_pkg::*;
(
    input  logic                 sgn_i,
    input  logic signed [XW-1:0] exp_i,
    input  logic [PROD_W-1:0]    prod_i,
    output logic [WORD_W-1:0]    word_o,
    output logic                 ovf_o,
    output logic                 unf_o
);
    localparam logic signed [XW-1:0] EXP_SAT = EXP_TOP[XW-1:0];

    logic                 top_bit;
    logic [PROD_W-1:0]    aligned;
    logic [SIG_W-1:0]     kept;
    logic                 guard_b;
    logic                 round_b;
    logic                 sticky_b;
    logic                 bump;
    logic [SIG_W:0]       rsum;
    logic signed [XW-1:0] exp_n;
    logic signed [XW-1:0] exp_r;
    logic [FRAC_W-1:0]    frac_r;

    always_comb begin
        // step: normalize a product of 2.0 or more
        top_bit  = prod_i[PROD_W-1];
        aligned  = top_bit ? prod_i : {prod_i[PROD_W-2:0], 1'b0};
        exp_n    = top_bit ? exp_i + XW'(1) : exp_i;
        kept     = aligned[PROD_W-1 -: SIG_W];
        guard_b  = aligned[PROD_W-1-SIG_W];
        round_b  = aligned[PROD_W-2-SIG_W];
        sticky_b = |aligned[PROD_W-3-SIG_W:0];
        // step: nearest, ties to even
        bump     = guard_b & (round_b | sticky_b | kept[0]);
        rsum     = {1'b0, kept} + {{SIG_W{1'b0}}, bump};
        if (rsum[SIG_W]) begin
            frac_r = '0;
            exp_r  = exp_n + XW'(1);
        end else begin
            frac_r = rsum[FRAC_W-1:0];
            exp_r  = exp_n;
        end
        // step: range check and pack
        ovf_o = !exp_r[XW-1] && (exp_r >= EXP_SAT);
        unf_o = exp_r[XW-1] || (exp_r == '0);
        if (ovf_o)
            word_o = {sgn_i, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (unf_o)
            word_o = {sgn_i, {(WORD_W-1){1'b0}}};
        else
            word_o = {sgn_i, exp_r[EXP_W-1:0], frac_r};
    end
endmodule

// File: rtl/fpm_mul.sv
module fpm_mul
    import fpm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid_i,
    input  logic [31:0] a_i,
    input  logic [31:0] b_i,
    output logic        out_valid_o,
    output logic [31:0] result_o,
    output logic        ovf_o,
    output logic        unf_o
);
    localparam logic [WORD_W-1:0] QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    fpm_opnd_t         op_a;
    fpm_opnd_t         op_b;
    fpm_state_t        st_d;
    fpm_state_t        st_q;
    logic [WORD_W-1:0] rnd_word;
    logic              rnd_ovf;
    logic              rnd_unf;
    logic              any_nan;
    logic              any_inf;
    logic              any_zero;

    fpm_unpack u_unpack_a (.word_i(a_i), .opnd_o(op_a));
    fpm_unpack u_unpack_b (.word_i(b_i), .opnd_o(op_b));

    fpm_round u_round (
        .sgn_i  (st_q.s1.sgn),
        .exp_i  (st_q.s1.exp),
        .prod_i (st_q.s1.prod),
        .word_o (rnd_word),
        .ovf_o  (rnd_ovf),
        .unf_o  (rnd_unf)
    );

    always_comb begin
        st_d = st_q;
        // stage 1: classify, sign, exponent sum, significand product
        any_nan  = (op_a.cls == CLS_NAN) || (op_b.cls == CLS_NAN);
        any_inf  = (op_a.cls == CLS_INF) || (op_b.cls == CLS_INF);
        any_zero = (op_a.cls == CLS_ZERO) || (op_b.cls == CLS_ZERO);
        st_d.s1.vld  = in_valid_i;
        st_d.s1.sgn  = op_a.sgn ^ op_b.sgn;
        st_d.s1.exp  = $signed(XW'(op_a.exp) + XW'(op_b.exp) - XW'(BIAS));
        st_d.s1.prod = PROD_W'(op_a.sig) * PROD_W'(op_b.sig);
        if (any_nan || (any_inf && any_zero))
            st_d.s1.kind = KIND_NAN;
        else if (any_inf)
            st_d.s1.kind = KIND_INF;
        else if (any_zero)
            st_d.s1.kind = KIND_ZERO;
        else
            st_d.s1.kind = KIND_NUM;
        // stage 2: round and resolve special results
        st_d.s2.vld = st_q.s1.vld;
        st_d.s2.ovf = 1'b0;
        st_d.s2.unf = 1'b0;
        unique case (st_q.s1.kind)
            KIND_NAN:  st_d.s2.word = QNAN;
            KIND_INF:  st_d.s2.word = {st_q.s1.sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            KIND_ZERO: st_d.s2.word = {st_q.s1.sgn, {(WORD_W-1){1'b0}}};
            default: begin
                st_d.s2.word = rnd_word;
                st_d.s2.ovf  = rnd_ovf;
                st_d.s2.unf  = rnd_unf;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid_o = st_q.s2.vld;
    assign result_o    = st_q.s2.word;
    assign ovf_o       = st_q.s2.ovf;
    assign unf_o       = st_q.s2.unf;

    p_sign_xor_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> (st_q.s1.sgn == ($past(a_i[31]) ^ $past(b_i[31]))));

    p_stage1_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid_i |=> st_q.s1.vld);

    p_stage2_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.s1.vld |=> out_valid_o);

    p_ovf_is_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (result_o[30:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    p_unf_is_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> (result_o[30:0] == '0));

    p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, unf_o}));

    p_nan_canonical_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && (result_o[30:23] == 8'hFF) && (result_o[22:0] != '0))
        |-> ((result_o == QNAN) && !ovf_o && !unf_o));
endmodule

// File: tb/fpm_mul_bench.sv
`timescale 1ns/1ps
module fpm_mul_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic        out_valid_o;
    logic [31:0] result_o;
    logic        ovf_o;
    logic        unf_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    fpm_mul u_fpm_mul (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i),
        .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o),
        .result_o(result_o), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // single operation: drive at a falling edge, sample two edges later
    task automatic run_op(input string req, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] exp_res, input logic eo, input logic eu);
        @(negedge clk);
        in_valid_i = 1'b1; a_i = a; b_i = b;
        @(negedge clk);
        in_valid_i = 1'b0; a_i = '0; b_i = '0;
        @(negedge clk);
        chk(req, result_o, exp_res);
        chk({req, " flags(valid,ovf,unf)"}, {29'd0, out_valid_o, ovf_o, unf_o}, {29'd0, 1'b1, eo, eu});
    endtask

    task automatic t_reset;
        chk("R10 reset result", result_o, 32'h0);
        chk("R10 reset valid/flags", {29'd0, out_valid_o, ovf_o, unf_o}, 32'h0);
    endtask

    task automatic t_normal;
        run_op("R2 2*3", 32'h40000000, 32'h40400000, 32'h40C00000, 0, 0);
        run_op("R2 1.5*1.5 normalize", 32'h3FC00000, 32'h3FC00000, 32'h40100000, 0, 0);
        run_op("R1 0.5*-0.4375", 32'h3F000000, 32'hBEE00000, 32'hBE600000, 0, 0);
        run_op("R1 -2*-3", 32'hC0000000, 32'hC0400000, 32'h40C00000, 0, 0);
    endtask

    task automatic t_rounding;
        run_op("R3 sticky only rounds down", 32'h3F800001, 32'h3F800001, 32'h3F800002, 0, 0);
        run_op("R3 tie odd rounds up", 32'h3F800001, 32'h3FC00000, 32'h3FC00002, 0, 0);
        run_op("R3 tie even stays", 32'h3F800003, 32'h3FC00000, 32'h3FC00004, 0, 0);
        run_op("R3 rounding carry renormalizes", 32'h3F800001, 32'h3FFFFFFE, 32'h40000000, 0, 0);
    endtask

    task automatic t_overflow;
        run_op("R4 overflow positive", 32'h7F000000, 32'h40000000, 32'h7F800000, 1, 0);
        run_op("R4 overflow negative", 32'hFF000000, 32'h40000000, 32'hFF800000, 1, 0);
        run_op("R4 largest normal kept", 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, 0, 0);
    endtask

    task automatic t_underflow;
        run_op("R5 underflow positive", 32'h00800000, 32'h3F000000, 32'h00000000, 0, 1);
        run_op("R5 underflow negative", 32'h80800000, 32'h3F000000, 32'h80000000, 0, 1);
        run_op("R5 smallest normal kept", 32'h00800000, 32'h3F800000, 32'h00800000, 0, 0);
    endtask

    task automatic t_nan;
        run_op("R6 quiet nan input", 32'h7FC00001, 32'h3F800000, 32'h7FC00000, 0, 0);
        run_op("R6 signalling nan input", 32'h40000000, 32'hFF800001, 32'h7FC00000, 0, 0);
        run_op("R6 inf times zero", 32'h7F800000, 32'h80000000, 32'h7FC00000, 0, 0);
        run_op("R6 inf times denormal", 32'h00000001, 32'hFF800000, 32'h7FC00000, 0, 0);
    endtask

    task automatic t_inf;
        run_op("R7 inf times negative", 32'h7F800000, 32'hC0000000, 32'hFF800000, 0, 0);
        run_op("R7 inf times inf", 32'hFF800000, 32'hFF800000, 32'h7F800000, 0, 0);
    endtask

    task automatic t_zero;
        run_op("R8 negative zero times 3", 32'h80000000, 32'h40400000, 32'h80000000, 0, 0);
        run_op("R8 denormal flushed", 32'h00000001, 32'h40000000, 32'h00000000, 0, 0);
        run_op("R8 zero times largest", 32'h7F7FFFFF, 32'h80000000, 32'h80000000, 0, 0);
    endtask

    task automatic t_stream;
        @(negedge clk);
        in_valid_i = 1'b1; a_i = 32'h40000000; b_i = 32'h40400000;
        @(negedge clk);
        chk("R9 no result after one edge", {31'd0, out_valid_o}, 32'd0);
        a_i = 32'h3FC00000; b_i = 32'h3FC00000;
        @(negedge clk);
        chk("R9 stream first valid", {31'd0, out_valid_o}, 32'd1);
        chk("R9 stream first result", result_o, 32'h40C00000);
        a_i = 32'h7F000000; b_i = 32'h40000000;
        @(negedge clk);
        in_valid_i = 1'b0; a_i = '0; b_i = '0;
        chk("R9 stream second result", result_o, 32'h40100000);
        @(negedge clk);
        chk("R9 stream third result", result_o, 32'h7F800000);
        chk("R9 stream third flags", {29'd0, out_valid_o, ovf_o, unf_o}, {29'd0, 3'b110});
        @(negedge clk);
        chk("R9 valid drops after stream", {31'd0, out_valid_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        t_normal;
        t_rounding;
        t_overflow;
        t_underflow;
        t_nan;
        t_inf;
        t_zero;
        t_stream;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule